// File: doc/BRIEF.md
# Reversal-Shifter Integer ALU

This block is the integer result stage of a 64-bit RISC-style pipeline. It takes a 5-bit operation code, a width select, two operands and a sum that an adder outside the block has already produced. From these it forms one 64-bit result with no clock and no state. It performs pass-through of the sum for add and subtract, the three bitwise logic operations, and left, logical-right and arithmetic-right shifts. Two optional groups can be added: rotates, and extraction of a single operand bit.

There is only one barrel shifter, and it shifts right. A left shift mirrors the prepared operand bit by bit, shifts it right, and mirrors the output back. Right shifts, rotate-right and bit extract skip the mirroring. Two elaboration parameters enable the optional groups. When a group is off, its codes are absent from the mirroring decision and from the result selection. In that case no comparator for those codes remains in the netlist, and the codes behave like any unused code.

In 32-bit mode only the low word of each operand takes part in the operation. The low 32 bits of the result are sign-extended to 64 bits. The block sits between decode and writeback. It relies on the decoder to send only the codes of enabled groups.

Top module: `revshift_alu`

## Requirements
- R1: Codes 0 (add) and 10 (subtract) return `sum_in`. In 32-bit mode they return the low half of `sum_in`, sign-extended from bit 31.
- R2: Code 1 shifts `opnd_a` left by the shift amount and fills the vacated bits with zeros.
- R3: Code 5 shifts `opnd_a` right logically with a zero fill. An amount of 0 returns the operand unchanged.
- R4: Code 11 shifts `opnd_a` right arithmetically. The vacated bits take the sign bit, which is bit 63 in 64-bit mode and bit 31 in 32-bit mode.
- R5: Codes 4, 6 and 7 return `opnd_a` XOR, OR and AND `opnd_b`, respectively.
- R6: `wide_sel`=1 selects 64-bit operation, with the shift amount taken from `opnd_b[5:0]`. `wide_sel`=0 selects 32-bit operation, with the amount taken from `opnd_b[4:0]`. In 32-bit mode, result bits 63..32 all equal result bit 31.
- R7: With `ROT_EN`=1, code 17 rotates left and code 18 rotates right, within 64 or 32 bits according to the width. A rotate amount of 0 returns the operand unchanged.
- R8: With `ROT_EN`=0, codes 17 and 18 return zero for any operands.
- R9: With `BEXT_EN`=1, code 20 returns `opnd_a` bit number *amount* in result bit 0, with all other result bits zero.
- R10: With `BEXT_EN`=0, code 20 returns zero for any operands.
- R11: Every code not listed above returns zero for any operands and either width.
- R12: In 32-bit mode, bits 63..32 of `opnd_a` have no effect on the shift, rotate and extract results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 5 | Operation code |
| wide_sel | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| opnd_a | input | 64 | First operand, the one that is shifted, rotated or extracted from |
| opnd_b | input | 64 | Second operand; its low bits give the shift amount |
| sum_in | input | 64 | Sum or difference from the external adder |
| result | output | 64 | Operation result |

## Verification
Several functions of this block act on the same vector at once. The case the bench works hardest is a 32-bit shift or rotate. There, the operand preparation (upper-half fill), the bit mirroring and the final sign extension all act together. The bench provokes this by driving 32-bit left shifts, arithmetic right shifts and rotates with random values in the upper half of `opnd_a` and with amounts that move bit 31. A behavioural model works on 32-bit integers and then sign-extends. Each cycle, the bench compares both a build with the options enabled and a build with them disabled against that model.

// File: rtl/revalu_pkg.sv
package revalu_pkg;

    localparam int unsigned OPW = 5;

    localparam logic [OPW-1:0] OP_ADD  = 5'd0;
    localparam logic [OPW-1:0] OP_SLL  = 5'd1;
    localparam logic [OPW-1:0] OP_XOR  = 5'd4;
    localparam logic [OPW-1:0] OP_SRL  = 5'd5;
    localparam logic [OPW-1:0] OP_OR   = 5'd6;
    localparam logic [OPW-1:0] OP_AND  = 5'd7;
    localparam logic [OPW-1:0] OP_SUB  = 5'd10;
    localparam logic [OPW-1:0] OP_SRA  = 5'd11;
    localparam logic [OPW-1:0] OP_ROL  = 5'd17;
    localparam logic [OPW-1:0] OP_ROR  = 5'd18;
    localparam logic [OPW-1:0] OP_BEXT = 5'd20;

endpackage

// File: rtl/revalu_shift_core.sv
// Single right barrel shifter; optional mirroring on input and output turns it into a left shifter.
module revalu_shift_core #(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0]         opnd,
    input  logic [$clog2(XLEN)-1:0] amt,
    input  logic                    word32,
    input  logic                    arith,
    input  logic                    rev_en,
    output logic [XLEN-1:0]         prep,
    output logic [XLEN-1:0]         shout
);
    localparam int unsigned HALF = XLEN / 2;

    logic                   fill;
    logic [XLEN-1:0]        shin;
    logic [XLEN-1:0]        shraw;
    logic signed [XLEN:0]   ext;
    logic signed [XLEN:0]   shifted;

    // fill bit: sign of the active width for arithmetic shifts, zero otherwise
    assign fill = arith & (word32 ? opnd[HALF-1] : opnd[XLEN-1]);
    assign prep = word32 ? {{HALF{fill}}, opnd[HALF-1:0]} : opnd;

    for (genvar i = 0; i < XLEN; i++) begin : g_mirror
        assign shin[i]  = rev_en ? prep[XLEN-1-i]  : prep[i];
        assign shout[i] = rev_en ? shraw[XLEN-1-i] : shraw[i];
    end

    assign ext     = {fill, shin};
    assign shifted = ext >>> amt;
    assign shraw   = shifted[XLEN-1:0];

endmodule

// File: rtl/revalu_rot_unit.sv
// Completes a rotate: ORs the shifter output with the prepared operand moved the other way.
module revalu_rot_unit #(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0]         prep,
    input  logic [XLEN-1:0]         shout,
    input  logic [$clog2(XLEN)-1:0] amt,
    input  logic                    word32,
    input  logic                    left,
    output logic [XLEN-1:0]         rot
);
    localparam int unsigned AMTW = $clog2(XLEN);
    localparam int unsigned HALF = XLEN / 2;

    logic [AMTW:0]     span;
    logic [AMTW:0]     comp;
    logic [XLEN-1:0]   other;

    assign span  = word32 ? (AMTW+1)'(HALF) : (AMTW+1)'(XLEN);
    // amount 0 gives comp == span, which moves every bit out of the active width
    assign comp  = span - {1'b0, amt};
    assign other = left ? (prep >> comp) : (prep << comp);
    assign rot   = shout | other;

endmodule

// File: rtl/revshift_alu.sv
module revshift_alu #(
    parameter int unsigned XLEN    = 64,
    parameter bit          ROT_EN  = 1'b1,
    parameter bit          BEXT_EN = 1'b1
) (
    input  logic [4:0]      op_code,
    input  logic            wide_sel,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic [XLEN-1:0] sum_in,
    output logic [XLEN-1:0] result
);
    import revalu_pkg::*;

    localparam int unsigned AMTW = $clog2(XLEN);
    localparam int unsigned HALF = XLEN / 2;

    typedef struct packed {
        logic [XLEN-1:0] raw;
        logic [XLEN-1:0] fin;
    } res_t;

    res_t               res_d;
    logic               word32;
    logic [AMTW-1:0]    amt;
    logic               base_keep;
    logic               rot_keep;
    logic               bext_keep;
    logic               rot_hit;
    logic               bext_hit;
    logic [XLEN-1:0]    prep;
    logic [XLEN-1:0]    shout;
    logic [XLEN-1:0]    rot_val;
    logic               unused_b;

    assign word32   = ~wide_sel;
    assign amt      = word32 ? {1'b0, opnd_b[AMTW-2:0]} : opnd_b[AMTW-1:0];
    assign unused_b = ^opnd_b[XLEN-1:AMTW];

    // codes that feed the shifter unmirrored; optional ones exist only when enabled
    assign base_keep = (op_code == OP_SRL) | (op_code == OP_SRA);

    if (ROT_EN) begin : g_rot
        assign rot_keep = (op_code == OP_ROR);
        assign rot_hit  = (op_code == OP_ROL) | (op_code == OP_ROR);
        revalu_rot_unit #(.XLEN(XLEN)) u_rot (
            .prep   (prep),
            .shout  (shout),
            .amt    (amt),
            .word32 (word32),
            .left   (op_code == OP_ROL),
            .rot    (rot_val)
        );
    end else begin : g_no_rot
        assign rot_keep = 1'b0;
        assign rot_hit  = 1'b0;
        assign rot_val  = '0;
    end

    if (BEXT_EN) begin : g_bext
        assign bext_keep = (op_code == OP_BEXT);
        assign bext_hit  = (op_code == OP_BEXT);
    end else begin : g_no_bext
        assign bext_keep = 1'b0;
        assign bext_hit  = 1'b0;
    end

    revalu_shift_core #(.XLEN(XLEN)) u_shift (
        .opnd   (opnd_a),
        .amt    (amt),
        .word32 (word32),
        .arith  (op_code == OP_SRA),
        .rev_en (~(base_keep | rot_keep | bext_keep)),
        .prep   (prep),
        .shout  (shout)
    );

    always_comb begin
        res_d = '0;
        case (op_code)
            OP_ADD, OP_SUB:         res_d.raw = sum_in;
            OP_SLL, OP_SRL, OP_SRA: res_d.raw = shout;
            OP_XOR:                 res_d.raw = opnd_a ^ opnd_b;
            OP_OR:                  res_d.raw = opnd_a | opnd_b;
            OP_AND:                 res_d.raw = opnd_a & opnd_b;
            default:                res_d.raw = '0;
        endcase
        if (rot_hit)  res_d.raw = rot_val;
        if (bext_hit) res_d.raw = {{(XLEN-1){1'b0}}, shout[0]};
        res_d.fin = word32 ? {{HALF{res_d.raw[HALF-1]}}, res_d.raw[HALF-1:0]} : res_d.raw;
    end

    assign result = res_d.fin;

endmodule

// File: rtl/revshift_alu_chk.sv
module revshift_alu_chk #(
    parameter int unsigned XLEN    = 64,
    parameter bit          ROT_EN  = 1'b1,
    parameter bit          BEXT_EN = 1'b1
) (
    input logic [4:0]      op_code,
    input logic            wide_sel,
    input logic [XLEN-1:0] opnd_a,
    input logic [XLEN-1:0] opnd_b,
    input logic [XLEN-1:0] sum_in,
    input logic [XLEN-1:0] result
);
    import revalu_pkg::*;

    localparam int unsigned AMTW = $clog2(XLEN);
    localparam int unsigned HALF = XLEN / 2;

    logic is_rot;
    logic claimed;

    assign is_rot  = (op_code == OP_ROL) | (op_code == OP_ROR);
    assign claimed = (op_code == OP_ADD) | (op_code == OP_SUB) | (op_code == OP_SLL) |
                     (op_code == OP_SRL) | (op_code == OP_SRA) | (op_code == OP_XOR) |
                     (op_code == OP_OR)  | (op_code == OP_AND) |
                     (ROT_EN && is_rot) | (BEXT_EN && op_code == OP_BEXT);

    always_comb begin
        if (!$isunknown({op_code, wide_sel, opnd_a, opnd_b, sum_in, result})) begin
            if (wide_sel && (op_code == OP_ADD || op_code == OP_SUB))
                p_sum_pass_r1: assert (result == sum_in) else $error("sum pass-through broken");
            if (wide_sel && op_code == OP_SRL && opnd_b[AMTW-1:0] == '0)
                p_srl_zero_r3: assert (result == opnd_a) else $error("zero logical shift altered operand");
            if (!wide_sel)
                p_sext_r6: assert (result[XLEN-1:HALF] == {HALF{result[HALF-1]}}) else $error("32-bit result not sign-extended");
            if (!ROT_EN && is_rot)
                p_rot_off_r8: assert (result == '0) else $error("disabled rotate gave non-zero");
            if (BEXT_EN && op_code == OP_BEXT)
                p_bext_single_r9: assert (result[XLEN-1:1] == '0) else $error("extract set upper bits");
            if (!BEXT_EN && op_code == OP_BEXT)
                p_bext_off_r10: assert (result == '0) else $error("disabled extract gave non-zero");
            if (!claimed)
                p_unclaimed_zero_r11: assert (result == '0) else $error("unclaimed code gave non-zero");
        end
    end

endmodule

bind revshift_alu revshift_alu_chk #(.XLEN(XLEN), .ROT_EN(ROT_EN), .BEXT_EN(BEXT_EN)) u_chk (
    .op_code  (op_code),
    .wide_sel (wide_sel),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .sum_in   (sum_in),
    .result   (result)
);

// File: tb/sim_revshift_alu.sv
`timescale 1ns/1ps
module sim_revshift_alu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  op_code;
    logic        wide_sel;
    logic [63:0] opnd_a, opnd_b, sum_in;
    logic [63:0] res_on, res_off;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    revshift_alu #(.XLEN(64), .ROT_EN(1'b1), .BEXT_EN(1'b1)) u0 (
        .op_code(op_code), .wide_sel(wide_sel), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .sum_in(sum_in), .result(res_on));

    revshift_alu #(.XLEN(64), .ROT_EN(1'b0), .BEXT_EN(1'b0)) u1 (
        .op_code(op_code), .wide_sel(wide_sel), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .sum_in(sum_in), .result(res_off));

    // behavioural model written from the requirements
    function automatic logic [63:0] model(int op, bit w, logic [63:0] a, logic [63:0] b,
                                          logic [63:0] sum, bit rot, bit bx);
        logic [63:0] r;
        logic [31:0] a32, b32, r32;
        int s;
        r = 64'd0;
        if (w) begin
            s = int'(b[5:0]);
            case (op)
                0, 10: r = sum;
                1:  r = a << s;
                5:  r = a >> s;
                11: r = 64'($signed(a) >>> s);
                4:  r = a ^ b;
                6:  r = a | b;
                7:  r = a & b;
                17: r = !rot ? 64'd0 : (s == 0 ? a : (a << s) | (a >> (64 - s)));
                18: r = !rot ? 64'd0 : (s == 0 ? a : (a >> s) | (a << (64 - s)));
                20: r = bx ? ((a >> s) & 64'd1) : 64'd0;
                default: r = 64'd0;
            endcase
        end else begin
            s = int'(b[4:0]);
            a32 = a[31:0];
            b32 = b[31:0];
            case (op)
                0, 10: r32 = sum[31:0];
                1:  r32 = a32 << s;
                5:  r32 = a32 >> s;
                11: r32 = 32'($signed(a32) >>> s);
                4:  r32 = a32 ^ b32;
                6:  r32 = a32 | b32;
                7:  r32 = a32 & b32;
                17: r32 = !rot ? 32'd0 : (s == 0 ? a32 : (a32 << s) | (a32 >> (32 - s)));
                18: r32 = !rot ? 32'd0 : (s == 0 ? a32 : (a32 >> s) | (a32 << (32 - s)));
                20: r32 = bx ? ((a32 >> s) & 32'd1) : 32'd0;
                default: r32 = 32'd0;
            endcase
            r = {{32{r32[31]}}, r32};
        end
        return r;
    endfunction

    function automatic string tag_of(int op, bit opts);
        case (op)
            0, 10:   return "R1";
            1:       return "R2";
            5:       return "R3";
            11:      return "R4";
            4, 6, 7: return "R5";
            17, 18:  return opts ? "R7" : "R8";
            20:      return opts ? "R9" : "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive at a rising edge, compare both builds at the next falling edge
    task automatic apply(int op, bit w, logic [63:0] a, logic [63:0] b, logic [63:0] sum, string req);
        @(posedge clk);
        op_code  = 5'(op);
        wide_sel = w;
        opnd_a   = a;
        opnd_b   = b;
        sum_in   = sum;
        @(negedge clk);
        check(req == "" ? tag_of(op, 1'b1) : req, $sformatf("on op=%0d w=%0d", op, w),
              res_on, model(op, w, a, b, sum, 1'b1, 1'b1));
        check(req == "" ? tag_of(op, 1'b0) : req, $sformatf("off op=%0d w=%0d", op, w),
              res_off, model(op, w, a, b, sum, 1'b0, 1'b0));
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        op_code = 5'd0; wide_sel = 1'b1;
        opnd_a = '0; opnd_b = '0; sum_in = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "idle state on", res_on, 64'd0);
        check("R1", "idle state off", res_off, 64'd0);

        // directed corners
        apply(1, 1'b1, 64'h8000_0000_0000_0001, 64'd63, 64'd0, "R2");       // left by 63
        apply(11, 1'b1, 64'h8000_0000_0000_0000, 64'd63, 64'd0, "R4");      // sign fill 64
        apply(11, 1'b0, 64'hFFFF_FFFF_8000_0000, 64'd4, 64'd0, "R4");       // sign fill from bit 31
        apply(5, 1'b1, 64'hDEAD_BEEF_0123_4567, 64'd0, 64'd0, "R3");        // amount 0
        apply(0, 1'b0, 64'd0, 64'd0, 64'h0000_0001_8000_0000, "R6");        // sext of sum
        apply(1, 1'b0, 64'h1234_5678_0000_0001, 64'hFFFF_FFE0_0000_003F, 64'd0, "R6"); // amount low 5 bits
        apply(5, 1'b0, 64'hFFFF_FFFF_0000_0080, 64'd7, 64'd0, "R12");       // upper half ignored
        apply(18, 1'b0, 64'hABCD_0000_0000_0001, 64'd1, 64'd0, "R12");
        apply(18, 1'b1, 64'h0123_4567_89AB_CDEF, 64'd0, 64'd0, "R7");       // rotate by 0
        apply(17, 1'b0, 64'h0000_0000_8000_0001, 64'd0, 64'd0, "R7");
        apply(17, 1'b1, 64'h8000_0000_0000_0001, 64'd1, 64'd0, "R7");
        apply(20, 1'b1, 64'h8000_0000_0000_0000, 64'd63, 64'd0, "R9");      // top bit extract
        apply(20, 1'b0, 64'hFFFF_FFFF_7FFF_FFFF, 64'd31, 64'd0, "R9");
        apply(31, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 64'hFFFF_FFFF_FFFF_FFFF, "R11");
        apply(19, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 64'hFFFF_FFFF_FFFF_FFFF, "R11");

        // every code, both widths, random operands
        for (int op = 0; op < 32; op++) begin
            for (int w = 0; w < 2; w++) begin
                for (int k = 0; k < 24; k++) begin
                    apply(op, w[0], rnd64(), rnd64(), rnd64(), "");
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule